// File: doc/BRIEF.md
# Fixed-Priority Three-Way Stream Merge

This unit sits at one output port of a router and decides which of three contending input streams may use that port on the current cycle. Every stream uses a valid/ready handshake. Input 0 is the local injection port. Inputs 1 and 2 carry traffic that is already travelling through the network. The priority order is therefore not the index order: input 1 wins first, then input 2, and injection comes last.

The unit is purely combinational. The chosen input's message and valid pass to the output. The output's ready is returned to the chosen input alone. A word moves on any cycle where the chosen input is valid and the output is ready.

The clock and reset pins serve only the bound checker. The selection logic keeps no state from one cycle to the next. The message width is a parameter with a default of 44 bits.

Top module: `prio_stream_merge`

## Requirements
- R1: When no input is valid, `out_vld` is 0, `out_msg` is all zeros, and all three input readies are 0.
- R2: While `in1_vld` is 1, input 1 is selected, whatever the other inputs carry.
- R3: When `in1_vld` is 0 and `in2_vld` is 1, input 2 is selected.
- R4: Input 0 is selected only when `in0_vld` is 1 and both `in1_vld` and `in2_vld` are 0.
- R5: When an input is selected, `out_vld` is 1 and `out_msg` equals that input's full-width message.
- R6: The selected input's ready equals `out_rdy`. Every unselected input's ready is 0, even when `out_rdy` is 1. `out_vld` does not depend on `out_rdy`.
- R7: A lower-priority input that is held valid receives no ready for as long as a higher-priority input stays valid. Starvation is accepted.
- R8: The outputs depend only on the current cycle's inputs. Identical inputs give identical outputs, whatever happened on earlier cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, used only by the bound checker |
| rst_n | input | 1 | Active-low reset, used only by the bound checker |
| in0_msg | input | MSG_W | Injection input message |
| in0_vld | input | 1 | Injection input valid |
| in0_rdy | output | 1 | Injection input ready |
| in1_msg | input | MSG_W | Network input 1 message (highest priority) |
| in1_vld | input | 1 | Network input 1 valid |
| in1_rdy | output | 1 | Network input 1 ready |
| in2_msg | input | MSG_W | Network input 2 message |
| in2_vld | input | 1 | Network input 2 valid |
| in2_rdy | output | 1 | Network input 2 ready |
| out_msg | output | MSG_W | Merged output message |
| out_vld | output | 1 | Merged output valid |
| out_rdy | input | 1 | Merged output ready |

## Verification
Every result is due in the same cycle as its stimulus, because no register lies between the inputs and the outputs. The bench drives new inputs shortly after each rising edge. At the falling edge of the same cycle it compares every output against a behavioural model evaluated on those inputs. Directed patterns cover the empty case, each winner, backpressure and a long starvation run. A random phase then revisits the same input combinations after varied histories, to show that the outputs carry no memory of earlier cycles.

// File: rtl/prio_stream_merge.sv
module prio_stream_merge #(
  parameter int MSG_W = 44
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [MSG_W-1:0] in0_msg,
  input  logic             in0_vld,
  output logic             in0_rdy,
  input  logic [MSG_W-1:0] in1_msg,
  input  logic             in1_vld,
  output logic             in1_rdy,
  input  logic [MSG_W-1:0] in2_msg,
  input  logic             in2_vld,
  output logic             in2_rdy,
  output logic [MSG_W-1:0] out_msg,
  output logic             out_vld,
  input  logic             out_rdy
);

  logic take1, take2, take0;

  assign take1 = in1_vld;
  assign take2 = in2_vld & ~in1_vld;
  assign take0 = in0_vld & ~in1_vld & ~in2_vld;

  assign out_vld = take1 | take2 | take0;
  assign out_msg = ({MSG_W{take1}} & in1_msg)
                 | ({MSG_W{take2}} & in2_msg)
                 | ({MSG_W{take0}} & in0_msg);

  assign in1_rdy = take1 & out_rdy;
  assign in2_rdy = take2 & out_rdy;
  assign in0_rdy = take0 & out_rdy;

endmodule

// File: rtl/prio_stream_merge_chk.sv
module prio_stream_merge_chk #(
  parameter int MSG_W = 44
) (
  input logic             clk,
  input logic             rst_n,
  input logic [MSG_W-1:0] in0_msg,
  input logic             in0_vld,
  input logic             in0_rdy,
  input logic [MSG_W-1:0] in1_msg,
  input logic             in1_vld,
  input logic             in1_rdy,
  input logic [MSG_W-1:0] in2_msg,
  input logic             in2_vld,
  input logic             in2_rdy,
  input logic [MSG_W-1:0] out_msg,
  input logic             out_vld,
  input logic             out_rdy
);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!in0_vld && !in1_vld && !in2_vld) |->
      (!out_vld && out_msg == '0 && !in0_rdy && !in1_rdy && !in2_rdy));

  // R2
  net1_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in1_vld |-> (out_vld && out_msg == in1_msg && in1_rdy == out_rdy));

  // R3
  net2_second_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!in1_vld && in2_vld) |-> (out_vld && out_msg == in2_msg && in2_rdy == out_rdy));

  // R4
  inject_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in0_rdy |-> (in0_vld && !in1_vld && !in2_vld && out_msg == in0_msg));

  // R6
  one_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({in0_rdy, in1_rdy, in2_rdy}));

  // R6
  no_ready_when_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_rdy |-> ({in0_rdy, in1_rdy, in2_rdy} == 3'b000));

  // R7
  starve_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in1_vld || in2_vld) |-> !in0_rdy);

  // R8
  stateless_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(in0_vld) && $stable(in1_vld) && $stable(in2_vld) && $stable(out_rdy)
     && $stable(in0_msg) && $stable(in1_msg) && $stable(in2_msg))
      |-> ($stable(out_vld) && $stable(out_msg) && $stable(in0_rdy)
           && $stable(in1_rdy) && $stable(in2_rdy)));

endmodule

bind prio_stream_merge prio_stream_merge_chk #(.MSG_W(MSG_W)) u_chk (.*);

// File: tb/prio_stream_merge_tb.sv
module prio_stream_merge_tb;
  localparam int W = 44;

  logic clk = 0, rst_n = 0;
  logic [W-1:0] in0_msg = '0, in1_msg = '0, in2_msg = '0;
  logic in0_vld = 0, in1_vld = 0, in2_vld = 0, out_rdy = 0;
  logic in0_rdy, in1_rdy, in2_rdy, out_vld;
  logic [W-1:0] out_msg;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  prio_stream_merge #(.MSG_W(W)) u_dut (.*);

  // model: returns winner index or -1
  function automatic int winner();
    if (in1_vld) return 1;
    if (in2_vld) return 2;
    if (in0_vld) return 0;
    return -1;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic compare(input string req);
    int w = winner();
    logic [W-1:0] em;
    logic [2:0] er, ar;
    em = (w == 1) ? in1_msg : (w == 2) ? in2_msg : (w == 0) ? in0_msg : '0;
    er = '0;
    if (w >= 0) er[w] = out_rdy;
    ar = {in2_rdy, in1_rdy, in0_rdy};
    chk(out_vld == (w >= 0), req, "out_vld", W'(out_vld), W'(w >= 0));
    chk(out_msg == em, req, "out_msg", out_msg, em);
    chk(ar == er, req, "rdy{2,1,0}", W'(ar), W'(er));
  endtask

  task automatic step(input bit v0, v1, v2, r,
                      input logic [W-1:0] m0, m1, m2, input string req);
    @(posedge clk); #1;
    in0_vld = v0; in1_vld = v1; in2_vld = v2; out_rdy = r;
    in0_msg = m0; in1_msg = m1; in2_msg = m2;
    @(negedge clk);
    compare(req);
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    compare("R1 reset");
    // R1 idle with ready high
    step(0,0,0,1, 44'h111, 44'h222, 44'h333, "R1");
    // R2 all valid
    step(1,1,1,1, 44'hA00000000AA, 44'hB00000000BB, 44'hC00000000CC, "R2");
    step(1,1,0,1, 44'h1, 44'hFFFFFFFFFFF, 44'h3, "R2 R5");
    // R3
    step(1,0,1,1, 44'h0AB, 44'h0CD, 44'h0EF, "R3");
    step(0,0,1,1, 44'h0, 44'h0, 44'h80000000001, "R3 R5");
    // R4
    step(1,0,0,1, 44'h55555555555, 44'h0, 44'h0, "R4 R5");
    // R6 backpressure: unselected and selected all zero
    step(1,1,1,0, 44'h9, 44'h8, 44'h7, "R6");
    step(1,0,0,0, 44'h9, 44'h8, 44'h7, "R6");
    step(1,0,1,1, 44'h9, 44'h8, 44'h7, "R6");
    // R7 starvation of injection under long network stream
    for (int i = 0; i < 40; i++) begin
      step(1,1,(i%2)==1,1, 44'hDEAD, W'(i), 44'hBEEF, "R7");
      chk(in0_rdy == 0, "R7", "in0_rdy starved", W'(in0_rdy), '0);
    end
    step(1,0,0,1, 44'hDEAD, 44'h0, 44'h0, "R7 release");
    // R8 random, history-independent
    for (int i = 0; i < 400; i++) begin
      logic [3:0] b = 4'($urandom);
      step(b[0], b[1], b[2], b[3],
           {12'($urandom), 32'($urandom)}, {12'($urandom), 32'($urandom)},
           {12'($urandom), 32'($urandom)}, "R8");
    end
    step(1,1,1,1, 44'hA00000000AA, 44'hB00000000BB, 44'hC00000000CC, "R8 repeat");
    chk(out_msg == 44'hB00000000BB, "R8", "same inputs same output", out_msg, 44'hB00000000BB);
    step(0,0,0,0, '0, '0, '0, "R1 end");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule